// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block holds the status and timing state for batching several sector erases into one internal erase run behind a NOR-flash command interface. The command decoder in front of it turns bus unlock sequences into single-cycle strobes: one strobe for a complete sector-erase command, which carries a sector index, and one strobe for any other command. An erase engine behind it reports completion with a single-cycle done pulse.

The first valid sector-erase command makes the block busy and opens an accumulation window. While the window is open, more sector-erase commands are taken, each one sets its sector's bit in a bitmap and starts the window count again. If the window runs out with no new command, the block raises its timer status bit and enters the erase phase. In that phase every command strobe is ignored until the done pulse returns the block to read mode. Any other command that arrives while the window is open cancels the whole batch.

Top module: `sector_erase_window`

## Requirements
- R1: After reset the block is in read mode: busy_o = 0, window_closed_o = 0 and sector_map_o = 0.
- R2: In read mode, an erase_cmd_i strobe with a valid index takes effect at that clock edge. From the next cycle busy_o = 1 and window_closed_o = 0, and sector_map_o holds only bit k, where k is the value of erase_sector_i (bit 0 is sector 0).
- R3: In read mode, other_cmd_i and erase_done_i change none of the outputs.
- R4: While the window is open, a sector-erase command with a valid index sets that sector's bit in sector_map_o and keeps the bits already set. Naming a sector that is already set leaves the map unchanged.
- R5: window_closed_o stays 0 while the window is open. It rises exactly WINDOW_CYCLES clock edges after the edge that accepted the last sector-erase command, provided no command arrives in between.
- R6: Each accepted sector-erase command restarts the window count. This includes a command at the very edge on which the window would have expired: that command is accepted and window_closed_o stays 0.
- R7: other_cmd_i while the window is open cancels the batch, and from the next cycle busy_o = 0 and sector_map_o = 0. It takes priority over an erase_cmd_i strobe in the same cycle.
- R8: While window_closed_o = 1, erase_cmd_i and other_cmd_i are ignored: sector_map_o and window_closed_o keep their values.
- R9: erase_done_i while window_closed_o = 1 returns the block to read mode on the next cycle, with busy_o, window_closed_o and sector_map_o all 0.
- R10: erase_done_i while the window is open has no effect on the outputs or on the window timing.
- R11: A sector-erase command whose index is NUM_SECTORS or greater is not accepted, in any state, and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_cmd_i | input | 1 | Strobe for a decoded, complete sector-erase command |
| erase_sector_i | input | SEC_W | Sector index of the sector-erase command |
| other_cmd_i | input | 1 | Strobe for any other decoded command |
| erase_done_i | input | 1 | Pulse from the erase engine when the batch is finished |
| busy_o | output | 1 | High from the first accepted erase until it completes or is cancelled |
| window_closed_o | output | 1 | Timer status: 0 while accumulating, 1 during the internal erase |
| sector_map_o | output | NUM_SECTORS | Bitmap of the sectors queued for erase |

## Verification
An extra sector-erase command and the expiry of the window can fall on the same clock edge. The command must win and restart the count. The bench provokes this by waiting WINDOW_CYCLES-1 idle cycles after an accepted command and then sending the next command on the expiry edge. It judges the result by checking that the status bit is still 0 and that it rises only after a full window counted from that edge. A cancelling command in the same cycle as a sector-erase command is a second collision; the bench judges it by checking for an empty map and read mode, and the random phase hits both collisions again many times.

// File: rtl/sew_pkg.sv
package sew_pkg;
    typedef enum logic [1:0] {
        ST_READ   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_ERASE  = 2'd2
    } sew_state_e;
endpackage

// File: rtl/sew_sector_dec.sv
module sew_sector_dec #(
    parameter int NUM_SECTORS = 12,
    parameter int SEC_W       = 4
) (
    input  logic [SEC_W-1:0]       idx_i,
    output logic                   valid_o,
    output logic [NUM_SECTORS-1:0] onehot_o
);
    localparam logic [SEC_W:0] LIMIT = (SEC_W+1)'(NUM_SECTORS);

    assign valid_o = ({1'b0, idx_i} < LIMIT);

    for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_bit
        assign onehot_o[g] = (idx_i == SEC_W'(g));
    end
endmodule

// File: rtl/sew_window_timer.sv
module sew_window_timer #(
    parameter int WINDOW_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int CNT_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (run_i && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window #(
    parameter int NUM_SECTORS   = 12,
    parameter int WINDOW_CYCLES = 64,
    parameter int SEC_W         = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   erase_cmd_i,
    input  logic [SEC_W-1:0]       erase_sector_i,
    input  logic                   other_cmd_i,
    input  logic                   erase_done_i,
    output logic                   busy_o,
    output logic                   window_closed_o,
    output logic [NUM_SECTORS-1:0] sector_map_o
);
    import sew_pkg::*;

    typedef struct packed {
        sew_state_e             st;
        logic [NUM_SECTORS-1:0] map;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                   sec_valid;
    logic [NUM_SECTORS-1:0] sec_bit;
    logic                   take_erase;
    logic                   restart;
    logic                   expire;

    sew_sector_dec #(
        .NUM_SECTORS(NUM_SECTORS),
        .SEC_W      (SEC_W)
    ) u_dec (
        .idx_i   (erase_sector_i),
        .valid_o (sec_valid),
        .onehot_o(sec_bit)
    );

    sew_window_timer #(
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .run_i    (ctl_q.st == ST_WINDOW),
        .expire_o (expire)
    );

    assign take_erase = erase_cmd_i && sec_valid;

    always_comb begin
        ctl_d   = ctl_q;
        restart = 1'b0;
        case (ctl_q.st)
            ST_READ: begin
                if (take_erase) begin
                    ctl_d.st  = ST_WINDOW;
                    ctl_d.map = sec_bit;
                    restart   = 1'b1;
                end
            end
            ST_WINDOW: begin
                if (other_cmd_i) begin
                    ctl_d.st  = ST_READ;
                    ctl_d.map = '0;
                end else if (take_erase) begin
                    ctl_d.map = ctl_q.map | sec_bit;
                    restart   = 1'b1;
                end else if (expire) begin
                    ctl_d.st = ST_ERASE;
                end
            end
            ST_ERASE: begin
                if (erase_done_i) begin
                    ctl_d.st  = ST_READ;
                    ctl_d.map = '0;
                end
            end
            default: begin
                ctl_d.st  = ST_READ;
                ctl_d.map = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_READ;
            ctl_q.map <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o          = (ctl_q.st != ST_READ);
    assign window_closed_o = (ctl_q.st == ST_ERASE);
    assign sector_map_o    = ctl_q.map;
endmodule

// File: rtl/sew_checker.sv
module sew_checker #(
    parameter int NUM_SECTORS = 12,
    parameter int SEC_W       = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   erase_cmd_i,
    input logic [SEC_W-1:0]       erase_sector_i,
    input logic                   other_cmd_i,
    input logic                   erase_done_i,
    input logic                   busy_o,
    input logic                   window_closed_o,
    input logic [NUM_SECTORS-1:0] sector_map_o
);
    logic idx_ok;
    assign idx_ok = (int'(erase_sector_i) < NUM_SECTORS);

    // R1/R3: read mode never holds queued sectors
    a_r1_idle_map_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sector_map_o == '0));

    a_r5_status_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        window_closed_o |-> busy_o);

    a_r2_first_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && erase_cmd_i && idx_ok) |=>
            (busy_o && !window_closed_o && $countones(sector_map_o) == 1));

    a_r11_bad_index_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !idx_ok) |=> !busy_o);

    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !window_closed_o && other_cmd_i) |=> (!busy_o && sector_map_o == '0));

    a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (window_closed_o && !erase_done_i) |=> (window_closed_o && $stable(sector_map_o)));

    a_r9_done: assert property (@(posedge clk) disable iff (!rst_n)
        (window_closed_o && erase_done_i) |=> (!busy_o && !window_closed_o && sector_map_o == '0));

    a_r6_cmd_blocks_close: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !window_closed_o && erase_cmd_i && idx_ok && !other_cmd_i) |=> !window_closed_o);

    a_r4_map_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !window_closed_o && !other_cmd_i) |=>
            ((sector_map_o & $past(sector_map_o)) == $past(sector_map_o)));
endmodule

bind sector_erase_window sew_checker #(
    .NUM_SECTORS(NUM_SECTORS),
    .SEC_W      (SEC_W)
) u_sew_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .erase_cmd_i    (erase_cmd_i),
    .erase_sector_i (erase_sector_i),
    .other_cmd_i    (other_cmd_i),
    .erase_done_i   (erase_done_i),
    .busy_o         (busy_o),
    .window_closed_o(window_closed_o),
    .sector_map_o   (sector_map_o)
);

// File: tb/sector_erase_window_tb.sv
`timescale 1ns/1ps
module sector_erase_window_tb;
    localparam int NS = 12;
    localparam int W  = 8;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ec = 1'b0;
    logic [SW-1:0] sec = '0;
    logic          oc = 1'b0;
    logic          dn = 1'b0;
    logic          busy, closed;
    logic [NS-1:0] map;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // reference model state
    logic          m_busy, m_closed;
    logic [NS-1:0] m_map;
    int            m_cnt;

    always #2.5 clk = ~clk;

    sector_erase_window #(.NUM_SECTORS(NS), .WINDOW_CYCLES(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .erase_cmd_i(ec), .erase_sector_i(sec),
        .other_cmd_i(oc), .erase_done_i(dn), .busy_o(busy),
        .window_closed_o(closed), .sector_map_o(map)
    );

    function automatic logic [NS-1:0] bit_of(input int k);
        logic [NS-1:0] v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    function automatic bit idx_valid(input logic [SW-1:0] k);
        return int'(k) < NS;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 0; m_closed <= 0; m_map <= '0; m_cnt <= 0;
        end else if (!m_busy) begin
            if (ec && idx_valid(sec)) begin
                m_busy <= 1; m_map <= bit_of(int'(sec)); m_cnt <= 0;
            end
        end else if (!m_closed) begin
            if (oc) begin
                m_busy <= 0; m_map <= '0;
            end else if (ec && idx_valid(sec)) begin
                m_map <= m_map | bit_of(int'(sec)); m_cnt <= 0;
            end else if (m_cnt == W - 1) begin
                m_closed <= 1;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end else if (dn) begin
            m_busy <= 0; m_closed <= 0; m_map <= '0;
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // compare at negedge, away from the active edge
    task automatic chk(input string tag);
        checks++;
        if (busy !== m_busy || closed !== m_closed || map !== m_map) begin
            errors++;
            $display("FAIL %s: busy=%0b closed=%0b map=%h expected busy=%0b closed=%0b map=%h",
                     tag, busy, closed, map, m_busy, m_closed, m_map);
        end
    endtask

    task automatic chk_val(input string tag, input logic b, input logic c, input logic [NS-1:0] m);
        checks++;
        if (busy !== b || closed !== c || map !== m) begin
            errors++;
            $display("FAIL %s: busy=%0b closed=%0b map=%h expected busy=%0b closed=%0b map=%h",
                     tag, busy, closed, map, b, c, m);
        end
    endtask

    // drive at negedge, advance one edge, return at the next negedge
    task automatic cyc(input logic e, input int s, input logic o, input logic d);
        ec = e; sec = SW'(s); oc = o; dn = d;
        @(negedge clk);
        ec = 0; oc = 0; dn = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        process::self().srandom(32'h5EC7_0001);
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_val("R1 reset", 0, 0, '0);

        cyc(0, 0, 1, 0); chk_val("R3 other cmd idle", 0, 0, '0);
        cyc(0, 0, 0, 1); chk_val("R3 done idle", 0, 0, '0);
        cyc(1, 13, 0, 0); chk_val("R11 bad index idle", 0, 0, '0);

        cyc(1, 3, 0, 0); chk_val("R2 first accept", 1, 0, bit_of(3));
        cyc(1, 7, 0, 0); chk_val("R4 add sector", 1, 0, bit_of(3) | bit_of(7));
        cyc(1, 7, 0, 0); chk_val("R4 duplicate", 1, 0, bit_of(3) | bit_of(7));
        cyc(1, 15, 0, 0); chk_val("R11 bad index window", 1, 0, bit_of(3) | bit_of(7));
        // the R11 command did not restart: W-1 edges since last accept so far = 1
        cyc(0, 0, 0, 1); chk_val("R10 done in window", 1, 0, bit_of(3) | bit_of(7));
        idle(W - 3); chk_val("R5 still open", 1, 0, bit_of(3) | bit_of(7));
        cyc(0, 0, 0, 0); chk_val("R5 closes after window", 1, 1, bit_of(3) | bit_of(7));

        cyc(1, 1, 0, 0); chk_val("R8 erase ignored", 1, 1, bit_of(3) | bit_of(7));
        cyc(0, 0, 1, 0); chk_val("R8 other ignored", 1, 1, bit_of(3) | bit_of(7));
        idle(5); chk_val("R8 held", 1, 1, bit_of(3) | bit_of(7));
        cyc(0, 0, 0, 1); chk_val("R9 done", 0, 0, '0);

        cyc(1, 0, 0, 0);
        idle(W - 1); chk_val("R6 last open cycle", 1, 0, bit_of(0));
        cyc(1, 11, 0, 0); chk_val("R6 cmd on expiry edge", 1, 0, bit_of(0) | bit_of(11));
        idle(W - 1); chk_val("R6 restarted window", 1, 0, bit_of(0) | bit_of(11));
        cyc(0, 0, 0, 0); chk_val("R6 closes after restart", 1, 1, bit_of(0) | bit_of(11));
        cyc(0, 0, 0, 1); chk_val("R9 done again", 0, 0, '0);

        cyc(1, 2, 0, 0);
        cyc(1, 4, 1, 0); chk_val("R7 abort priority", 0, 0, '0);
        cyc(1, 5, 0, 0); idle(2);
        cyc(0, 0, 1, 0); chk_val("R7 abort", 0, 0, '0);

        for (int i = 0; i < 4000; i++) begin
            string tag;
            tag = !m_busy ? "R2 random read" : (!m_closed ? "R4 random window" : "R8 random erase");
            cyc(($urandom % 5) == 0, int'($urandom % 16), ($urandom % 40) == 0, ($urandom % 6) == 0);
            chk(tag);
        end

        finish_run();
    end
endmodule